// File: doc/BRIEF.md
# Bit-Slip Serial-to-Parallel Converter

This block turns a serial bit stream, clocked one bit per clock, into parallel words of four bits. The serial source is picked from two inputs, so a loopback path can be switched in for test. The oldest bit of the internal shift register is driven back out, so a second instance can take the stream and widen the conversion. An internal phase counter sets when each word is loaded. It also drives a divide-by-4 output, a divide-by-8 output and a one-cycle word strobe.

With the width select low, a new word is presented every four clocks. With it high, a word is presented every eight clocks, which suits a pair of cascaded instances forming an eight-bit converter. Each rising edge of the asynchronous slip request makes the counter skip one count. This moves the word boundary one bit later in the stream, so a bit that used to land on output bit n now lands on bit n-1. Reset is synchronous and active-high.

Top module: `bitslip_deser`

## Requirements
- R1: The first serial bit of a word is placed on `par_q[0]`, the second on `par_q[1]`, the third on `par_q[2]` and the fourth on `par_q[3]`.
- R2: The sampled bit is `ser_a` when `src_sel` is 1 and `ser_b` when `src_sel` is 0.
- R3: With `mode8` at 0, `par_q` changes only at word loads, and a load follows every 4 counts. After reset releases, the first load happens on the 4th rising edge.
- R4: With `mode8` at 1, a load happens only when the 3-bit phase counter wraps, which is once every 8 counts.
- R5: `div4_clk` is bit 1 and `div8_clk` is bit 2 of the phase counter. The counter increments on every clock that is not a swallowed count.
- R6: A rising edge of `slip_req` passes through a two-flop synchronizer. The counter then holds for one clock on the third rising edge after the request is sampled high, and that clock produces no word load.
- R7: A `slip_req` held high for any length of time produces exactly one swallowed count. Another slip needs a new low-to-high transition.
- R8: While `rst` is high, the counter, the strobe, the shift register and `par_q` are cleared on each rising edge.
- R9: After each rising edge, `ser_out` carries the selected bit that was sampled three edges earlier.
- R10: `word_stb` is high for exactly the one cycle after each word load, and is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_a | input | 1 | Serial input A (loopback) |
| ser_b | input | 1 | Serial input B (line) |
| src_sel | input | 1 | 1 selects A, 0 selects B |
| mode8 | input | 1 | 0: load every 4 bits, 1: every 8 bits |
| slip_req | input | 1 | Asynchronous word-boundary slip request |
| par_q | output | 4 | Parallel word, bit 0 first in time |
| ser_out | output | 1 | Delayed serial stream for cascading |
| div4_clk | output | 1 | Bit clock divided by 4 |
| div8_clk | output | 1 | Bit clock divided by 8 |
| word_stb | output | 1 | One-cycle strobe with each parallel load |

## Verification
The hardest case to reach is a slip that lands on the very count that would otherwise load a word. In that case the load must be withheld, and the divider outputs must stretch by one cycle. Slip requests of random width, some lasting dozens of cycles, are issued at random phases across both width modes. Over thousands of cycles, every phase, including the terminal one, is hit many times, and each result is compared against an independent cycle model. Mid-run resets and changes of mode and source add the remaining corners.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    localparam int WORD_W = 4;
    localparam int CNT_W  = $clog2(2 * WORD_W);

    typedef struct packed {
        logic div4;
        logic div8;
        logic load;
    } div_out_t;

    function automatic logic at_boundary(input logic [CNT_W-1:0] c, input logic m8);
        return m8 ? (&c) : (&c[CNT_W-2:0]);
    endfunction
endpackage

// File: rtl/bsd_slip_sync.sv
module bsd_slip_sync (
    input  logic clk,
    input  logic rst,
    input  logic slip_async,
    output logic swallow
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= slip_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign swallow = s2 & ~s3;

    // R7: a held request yields one swallow only
    assert_single_slip_R7: assert property (@(posedge clk) disable iff (rst)
        swallow |=> !swallow);
endmodule

// File: rtl/bsd_divider.sv
module bsd_divider #(
    parameter int CNT_W = bsd_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode8,
    input  logic              swallow,
    output bsd_pkg::div_out_t dout
);
    logic [CNT_W-1:0] cnt;
    logic             term;

    assign term = bsd_pkg::at_boundary(cnt, mode8);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!swallow)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        dout.div4 = cnt[CNT_W-2];
        dout.div8 = cnt[CNT_W-1];
        dout.load = term & ~swallow;
    end

    // R6: a swallowed count freezes the phase
    assert_hold_on_slip_R6: assert property (@(posedge clk) disable iff (rst)
        swallow |=> $stable(cnt));
    // R8: reset leaves the phase at zero
    assert_reset_clear_R8: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0));
endmodule

// File: rtl/bsd_shifter.sv
module bsd_shifter #(
    parameter int WORD_W = bsd_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              load,
    output logic [WORD_W-1:0] par_q,
    output logic              ser_out,
    output logic              stb
);
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] sh_next;

    assign sh_next = {bit_in, sh[WORD_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            par_q <= '0;
            stb   <= 1'b0;
        end else begin
            sh  <= sh_next;
            stb <= load;
            if (load)
                par_q <= sh_next;
        end
    end

    assign ser_out = sh[0];

    // R3: the word moves only together with the strobe
    assert_par_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !stb |-> $stable(par_q));
    // R10: strobe lasts one cycle
    assert_stb_single_R10: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
    parameter int WORD_W = bsd_pkg::WORD_W,
    parameter int CNT_W  = bsd_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_a,
    input  logic              ser_b,
    input  logic              src_sel,
    input  logic              mode8,
    input  logic              slip_req,
    output logic [WORD_W-1:0] par_q,
    output logic              ser_out,
    output logic              div4_clk,
    output logic              div8_clk,
    output logic              word_stb
);
    logic              swallow;
    logic              bit_in;
    bsd_pkg::div_out_t dout;

    assign bit_in = src_sel ? ser_a : ser_b;

    bsd_slip_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .slip_async(slip_req),
        .swallow   (swallow)
    );

    bsd_divider #(.CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .mode8  (mode8),
        .swallow(swallow),
        .dout   (dout)
    );

    bsd_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_in),
        .load   (dout.load),
        .par_q  (par_q),
        .ser_out(ser_out),
        .stb    (word_stb)
    );

    assign div4_clk = dout.div4;
    assign div8_clk = dout.div8;
endmodule

// File: tb/bitslip_deser_tb.sv
module bitslip_deser_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_a = 1'b0, ser_b = 1'b0, src_sel = 1'b0, mode8 = 1'b0, slip_req = 1'b0;
    logic [3:0] par_q;
    logic       ser_out, div4_clk, div8_clk, word_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [2:0] m_cnt;
    logic       m_s1, m_s2, m_s3, m_stb;
    logic [7:0] m_hist;   // m_hist[0] newest sampled bit
    logic [3:0] m_par;
    int         since_rst;

    always #4 clk = ~clk;

    bitslip_deser u_dut (
        .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b), .src_sel(src_sel),
        .mode8(mode8), .slip_req(slip_req), .par_q(par_q), .ser_out(ser_out),
        .div4_clk(div4_clk), .div8_clk(div8_clk), .word_stb(word_stb)
    );

    function automatic logic sel_bit(input logic s, input logic a, input logic b);
        return s ? a : b;   // R2
    endfunction

    function automatic logic is_term(input logic [2:0] c, input logic m8);
        return m8 ? (c == 3'd7) : (c[1:0] == 2'd3);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 3'd0; m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
            m_stb <= 1'b0; m_hist <= 8'd0; m_par <= 4'd0; since_rst <= 0;
        end else begin
            logic b, sw;
            logic [7:0] h;
            b  = sel_bit(src_sel, ser_a, ser_b);
            sw = m_s2 & ~m_s3;
            h  = {m_hist[6:0], b};
            m_hist <= h;
            m_s1 <= slip_req; m_s2 <= m_s1; m_s3 <= m_s2;
            if (!sw && is_term(m_cnt, mode8)) begin
                m_par <= {h[0], h[1], h[2], h[3]};  // R1: oldest of four on bit 0
                m_stb <= 1'b1;
            end else begin
                m_stb <= 1'b0;
            end
            if (!sw) m_cnt <= m_cnt + 3'd1;
            since_rst <= since_rst + 1;
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done && since_rst > 0) begin
            chk("R1/R3/R4 par_q", par_q, m_par);
            chk("R10 word_stb", {3'd0, word_stb}, {3'd0, m_stb});
            chk("R5 div4_clk", {3'd0, div4_clk}, {3'd0, m_cnt[1]});
            chk("R5/R6/R7 div8_clk", {3'd0, div8_clk}, {3'd0, m_cnt[2]});
            chk("R9 ser_out", {3'd0, ser_out}, {3'd0, m_hist[3]});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        cyc(2);
        // R8: cleared state
        chk("R8 par_q reset", par_q, 4'd0);
        chk("R8 outputs reset", {ser_out, div4_clk, div8_clk, word_stb}, 4'd0);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // directed R3 + R1: known pattern on B, first load on 4th edge
        src_sel = 1'b0; mode8 = 1'b0;
        begin
            logic [3:0] pat;
            pat = 4'b1101;
            for (int i = 0; i < 4; i++) begin
                ser_b = pat[i];
                @(negedge clk);
                if (i < 3) chk("R3 no early strobe", {3'd0, word_stb}, 4'd0);
            end
            chk("R3 first strobe at 4th edge", {3'd0, word_stb}, 4'd1);
            chk("R1 bit order", par_q, pat);
        end
        // directed R2: A selected
        src_sel = 1'b1; ser_b = 1'b0;
        for (int i = 0; i < 4; i++) begin ser_a = 1'b1; @(negedge clk); end
        chk("R2 source A word", par_q, 4'hF);
        // directed R7: long held slip
        slip_req = 1'b1; cyc(40); slip_req = 1'b0; cyc(6);
        // random phase
        for (int seg = 0; seg < 40; seg++) begin
            mode8   = $urandom_range(0, 1);
            src_sel = $urandom_range(0, 1);
            if (seg % 13 == 12) do_reset();
            for (int k = 0; k < 100; k++) begin
                ser_a = $urandom_range(0, 1);
                ser_b = $urandom_range(0, 1);
                if ($urandom_range(0, 19) == 0) slip_req = 1'b1;
                else if (slip_req && $urandom_range(0, 3) == 0) slip_req = 1'b0;
                @(negedge clk);
            end
            slip_req = 1'b0;
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule